// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the CPU-facing register interface of one eight-line interrupt controller. The CPU reaches it through two byte-wide addresses. Writes to the low address either start an initialization sequence or carry operation commands: end-of-interrupt, rotation, read selection, polling and special mask. Writes to the high address load the mask register, or the next initialization word while an initialization sequence is in progress. The block holds the mask register, the in-service register, the vector base, the rotation base and the mode flags, and drives them out on side-band ports to the priority resolver.

The request register and the priority resolver live outside this block. The sequencer reads the pending requests through `req_in`. It asks for request bits to be dropped with the one-cycle pulse `req_clr_o`. It learns the resolver's current winner through `win_valid`/`win_line`. An acknowledge strobe marks that winner as in service. In auto-EOI mode the acknowledge instead leaves the in-service register untouched and may rotate priority. A read returns its data on `rd_data` in the cycle after the read strobe.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset the mask, in-service register, vector base, rotation base, all mode flags and `rd_data` are zero, and no initialization is in progress.
- R2: A low-address write with bit 4 set starts initialization. The next high-address write sets the vector base to the data AND 0xF8. The following high-address write is discarded. It ends initialization unless bit 0 of the starting word was 1, in which case one more word is expected.
- R3: The optional fourth initialization word sets special fully nested mode from its bit 4 and auto-EOI from its bit 1, then returns to normal operation.
- R4: Starting initialization clears the mask, in-service register, rotation base, read select, poll, special-mask and all mode flags. For one cycle it also drives `req_clr_o` to all ones and pulses `int_clear_o`.
- R5: In normal operation a high-address write loads the mask register with the data.
- R6: A low-address write with bit 3 set and bit 4 clear is a read-control command. When bit 1 is set, bit 0 picks what a low-address read returns (1 = in-service, 0 = `req_in`). When bit 6 is set, bit 5 loads the special-mask flag. A high-address read returns the mask.
- R7: Command codes 0 and 4 in bits 7:5 (bits 4:3 clear) set rotate-on-auto-EOI to bit 7.
- R8: Code 1 clears the highest-priority in-service bit, with priority falling from the rotation base upward modulo 8. With an empty in-service register it changes nothing.
- R9: Code 5 clears the same bit as code 1 and sets the rotation base to that line plus one, modulo 8.
- R10: Code 3 clears the in-service bit named by bits 2:0. Code 7 does the same and sets the rotation base to that line plus one, modulo 8.
- R11: Code 6 sets the rotation base to bits 2:0 plus one, modulo 8. Code 2 changes no state.
- R12: Bit 2 of a read-control command arms poll. The next read then returns the winning line number, clears its in-service bit and pulses that bit alone on `req_clr_o`. If no line is winning, it returns 0x07. Poll is disarmed after that one read.
- R13: Bits 1 and 3 of the initialization start word are ignored. The sequence length and the resulting state depend only on bit 0.
- R14: An acknowledge sets the in-service bit of `win_line` when auto-EOI is off. With auto-EOI on, it leaves the in-service register unchanged and, if rotate-on-auto-EOI is set, moves the rotation base to that line plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register address (0 = command, 1 = data) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after the read strobe |
| req_in | input | 8 | Current request register from the request logic |
| win_valid | input | 1 | Resolver reports a winning line |
| win_line | input | 3 | Resolver's winning line number |
| ack_en | input | 1 | Interrupt acknowledge strobe for `win_line` |
| mask_o | output | 8 | Mask register |
| isr_o | output | 8 | In-service register |
| base_o | output | 8 | Vector base (low three bits zero) |
| rot_o | output | 3 | Rotation base: the line with highest priority |
| sfnm_o | output | 1 | Special fully nested mode |
| aeoi_o | output | 1 | Auto-EOI mode |
| rotae_o | output | 1 | Rotate on auto-EOI |
| smask_o | output | 1 | Special-mask flag |
| init_busy_o | output | 1 | Initialization sequence in progress |
| req_clr_o | output | 8 | One-cycle request clear pulses |
| int_clear_o | output | 1 | One-cycle pulse: drop the interrupt output |

## Verification
The hardest cases to reach are the rotated non-specific end-of-interrupt and the destructive poll read. In the first, the bit to clear depends on the rotation base, so a simple lowest-bit search would go unnoticed. The stimulus sets up several in-service bits with acknowledges, moves the rotation base past the lowest of them with a set-priority command, and then checks that the bit that wraps around first is the one cleared. For poll, a line is first put in service. Poll is then armed with the resolver inputs presenting that line. The bench checks the returned number, the cleared bit and the request-clear pulse, then confirms that the next read is an ordinary register read.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [1:0] {
    STEP_RUN,
    STEP_BASE,
    STEP_CASC,
    STEP_MODE
  } step_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_INIT,
    OP_RDCTL,
    OP_ROTAE,
    OP_EOI_NS,
    OP_EOI_NS_ROT,
    OP_EOI_SP,
    OP_EOI_SP_ROT,
    OP_SETPRI,
    OP_MASK,
    OP_BASE,
    OP_CASC,
    OP_MODE
  } op_e;

endpackage

// File: rtl/irq_seq_decode.sv
module irq_seq_decode
  import irq_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] data,
  input  step_e         step,
  output op_e           op
);

  always_comb begin
    op = OP_NONE;
    if (wr_en) begin
      if (!addr) begin
        if (data[4]) begin
          op = OP_INIT;
        end else if (data[3]) begin
          op = OP_RDCTL;
        end else begin
          unique case (data[7:5])
            3'd0, 3'd4: op = OP_ROTAE;
            3'd1:       op = OP_EOI_NS;
            3'd5:       op = OP_EOI_NS_ROT;
            3'd3:       op = OP_EOI_SP;
            3'd7:       op = OP_EOI_SP_ROT;
            3'd6:       op = OP_SETPRI;
            default:    op = OP_NONE;
          endcase
        end
      end else begin
        unique case (step)
          STEP_RUN:  op = OP_MASK;
          STEP_BASE: op = OP_BASE;
          STEP_CASC: op = OP_CASC;
          default:   op = OP_MODE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_seq_isr_pick.sv
module irq_seq_isr_pick #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] isr,
  input  logic [LW-1:0]    rot,
  output logic             found,
  output logic [LW-1:0]    line
);

  always_comb begin
    found = 1'b0;
    line  = '0;
    for (int i = 0; i < LINES; i++) begin
      int k;
      k = (int'(rot) + i) % LINES;
      if (!found && isr[k]) begin
        found = 1'b1;
        line  = LW'(k);
      end
    end
  end

endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_seq_pkg::*;
#(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES),
  localparam int DW = LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] req_in,
  input  logic          win_valid,
  input  logic [LW-1:0] win_line,
  input  logic          ack_en,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] isr_o,
  output logic [DW-1:0] base_o,
  output logic [LW-1:0] rot_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          rotae_o,
  output logic          smask_o,
  output logic          init_busy_o,
  output logic [DW-1:0] req_clr_o,
  output logic          int_clear_o
);

  localparam logic [DW-1:0] BASE_KEEP = ~DW'((1 << LW) - 1);
  localparam logic [DW-1:0] NO_LINE   = DW'(LINES - 1);

  step_e         step_q, step_d;
  logic          need4_q, need4_d;
  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] isr_q, isr_d;
  logic [DW-1:0] base_q, base_d;
  logic [LW-1:0] rot_q, rot_d;
  logic          rdsel_q, rdsel_d;
  logic          poll_q, poll_d;
  logic          smask_q, smask_d;
  logic          aeoi_q, aeoi_d;
  logic          rotae_q, rotae_d;
  logic          sfnm_q, sfnm_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [DW-1:0] rclr_q, rclr_d;
  logic          kill_q, kill_d;

  op_e           op;
  logic          pick_found;
  logic [LW-1:0] pick_line;
  logic [LW-1:0] cmd_line;

  assign cmd_line = wr_data[LW-1:0];

  irq_seq_decode #(.DW(DW)) u_decode (
    .wr_en (wr_en),
    .addr  (addr),
    .data  (wr_data),
    .step  (step_q),
    .op    (op)
  );

  irq_seq_isr_pick #(.LINES(LINES)) u_pick (
    .isr   (isr_q),
    .rot   (rot_q),
    .found (pick_found),
    .line  (pick_line)
  );

  // Next state: write command first, then acknowledge, then read.
  always_comb begin
    step_d  = step_q;
    need4_d = need4_q;
    mask_d  = mask_q;
    isr_d   = isr_q;
    base_d  = base_q;
    rot_d   = rot_q;
    rdsel_d = rdsel_q;
    poll_d  = poll_q;
    smask_d = smask_q;
    aeoi_d  = aeoi_q;
    rotae_d = rotae_q;
    sfnm_d  = sfnm_q;
    rd_d    = rd_q;
    rclr_d  = '0;
    kill_d  = 1'b0;

    unique case (op)
      OP_INIT: begin
        step_d  = STEP_BASE;
        need4_d = wr_data[0];
        mask_d  = '0;
        isr_d   = '0;
        base_d  = '0;
        rot_d   = '0;
        rdsel_d = 1'b0;
        poll_d  = 1'b0;
        smask_d = 1'b0;
        aeoi_d  = 1'b0;
        rotae_d = 1'b0;
        sfnm_d  = 1'b0;
        rclr_d  = '1;
        kill_d  = 1'b1;
      end
      OP_RDCTL: begin
        if (wr_data[2]) poll_d  = 1'b1;
        if (wr_data[1]) rdsel_d = wr_data[0];
        if (wr_data[6]) smask_d = wr_data[5];
      end
      OP_ROTAE: rotae_d = wr_data[7];
      OP_EOI_NS: begin
        if (pick_found) isr_d[pick_line] = 1'b0;
      end
      OP_EOI_NS_ROT: begin
        if (pick_found) begin
          isr_d[pick_line] = 1'b0;
          rot_d            = pick_line + 1'b1;
        end
      end
      OP_EOI_SP: isr_d[cmd_line] = 1'b0;
      OP_EOI_SP_ROT: begin
        isr_d[cmd_line] = 1'b0;
        rot_d           = cmd_line + 1'b1;
      end
      OP_SETPRI: rot_d = cmd_line + 1'b1;
      OP_MASK:   mask_d = wr_data;
      OP_BASE: begin
        base_d = wr_data & BASE_KEEP;
        step_d = STEP_CASC;
      end
      OP_CASC: step_d = need4_q ? STEP_MODE : STEP_RUN;
      OP_MODE: begin
        sfnm_d = wr_data[4];
        aeoi_d = wr_data[1];
        step_d = STEP_RUN;
      end
      default: ;
    endcase

    if (ack_en) begin
      if (aeoi_q) begin
        if (rotae_q) rot_d = win_line + 1'b1;
      end else begin
        isr_d[win_line] = 1'b1;
      end
    end

    if (rd_en) begin
      if (poll_q) begin
        poll_d = 1'b0;
        if (win_valid) begin
          rd_d             = DW'(win_line);
          isr_d[win_line]  = 1'b0;
          rclr_d[win_line] = 1'b1;
        end else begin
          rd_d = NO_LINE;
        end
      end else if (addr) begin
        rd_d = mask_q;
      end else begin
        rd_d = rdsel_q ? isr_q : req_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= STEP_RUN;
      need4_q <= 1'b0;
      mask_q  <= '0;
      isr_q   <= '0;
      base_q  <= '0;
      rot_q   <= '0;
      rdsel_q <= 1'b0;
      poll_q  <= 1'b0;
      smask_q <= 1'b0;
      aeoi_q  <= 1'b0;
      rotae_q <= 1'b0;
      sfnm_q  <= 1'b0;
      rd_q    <= '0;
      rclr_q  <= '0;
      kill_q  <= 1'b0;
    end else begin
      step_q  <= step_d;
      need4_q <= need4_d;
      mask_q  <= mask_d;
      isr_q   <= isr_d;
      base_q  <= base_d;
      rot_q   <= rot_d;
      rdsel_q <= rdsel_d;
      poll_q  <= poll_d;
      smask_q <= smask_d;
      aeoi_q  <= aeoi_d;
      rotae_q <= rotae_d;
      sfnm_q  <= sfnm_d;
      rd_q    <= rd_d;
      rclr_q  <= rclr_d;
      kill_q  <= kill_d;
    end
  end

  assign rd_data     = rd_q;
  assign mask_o      = mask_q;
  assign isr_o       = isr_q;
  assign base_o      = base_q;
  assign rot_o       = rot_q;
  assign sfnm_o      = sfnm_q;
  assign aeoi_o      = aeoi_q;
  assign rotae_o     = rotae_q;
  assign smask_o     = smask_q;
  assign init_busy_o = (step_q != STEP_RUN);
  assign req_clr_o   = rclr_q;
  assign int_clear_o = kill_q;

endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk #(
  parameter int LINES = 8,
  localparam int LW = $clog2(LINES),
  localparam int DW = LINES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic          ack_en,
  input logic [DW-1:0] mask_o,
  input logic [DW-1:0] isr_o,
  input logic [DW-1:0] base_o,
  input logic [LW-1:0] rot_o,
  input logic          init_busy_o,
  input logic [DW-1:0] req_clr_o,
  input logic          int_clear_o
);

  assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    base_o[LW-1:0] == '0);

  assert_init_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[4] && !ack_en) |=>
      (isr_o == '0 && mask_o == '0 && req_clr_o == '1 && int_clear_o && init_busy_o));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && !init_busy_o) |=> (mask_o == $past(wr_data)));

  assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[7:3] == 5'b00100 && isr_o == '0 && !ack_en) |=>
      (isr_o == '0 && $stable(rot_o)));

  assert_setpri_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[7:3] == 5'b11000 && !ack_en) |=>
      (rot_o == LW'($past(wr_data[LW-1:0]) + 1'b1)));

  assert_clr_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !int_clear_o |-> $onehot0(req_clr_o));

endmodule

bind irq_cmd_seq irq_cmd_seq_chk #(.LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .ack_en      (ack_en),
  .mask_o      (mask_o),
  .isr_o       (isr_o),
  .base_o      (base_o),
  .rot_o       (rot_o),
  .init_busy_o (init_busy_o),
  .req_clr_o   (req_clr_o),
  .int_clear_o (int_clear_o)
);

// File: tb/irq_cmd_seq_test.sv
module irq_cmd_seq_test;

  logic       clk;
  logic       rst_n;
  logic       addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [7:0] rd_data;
  logic [7:0] req_in;
  logic       win_valid;
  logic [2:0] win_line;
  logic       ack_en;
  logic [7:0] mask_o, isr_o, base_o, req_clr_o;
  logic [2:0] rot_o;
  logic       sfnm_o, aeoi_o, rotae_o, smask_o, init_busy_o, int_clear_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  irq_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .req_in(req_in), .win_valid(win_valid),
    .win_line(win_line), .ack_en(ack_en), .mask_o(mask_o), .isr_o(isr_o),
    .base_o(base_o), .rot_o(rot_o), .sfnm_o(sfnm_o), .aeoi_o(aeoi_o),
    .rotae_o(rotae_o), .smask_o(smask_o), .init_busy_o(init_busy_o),
    .req_clr_o(req_clr_o), .int_clear_o(int_clear_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic ack(logic [2:0] line);
    @(negedge clk);
    win_line = line; ack_en = 1'b1;
    @(negedge clk);
    ack_en = 1'b0;
  endtask

  task automatic init_seq(logic [7:0] w1, logic [7:0] base, logic [7:0] w4);
    wr(0, w1);
    wr(1, base);
    wr(1, 8'h00);
    if (w1[0]) wr(1, w4);
  endtask

  task automatic t_reset;
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 isr", isr_o, 8'h00);
    chk("R1 base", base_o, 8'h00);
    chk("R1 rot", {5'b0, rot_o}, 8'h00);
    chk("R1 flags", {2'b0, sfnm_o, aeoi_o, rotae_o, smask_o, init_busy_o, int_clear_o}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_init;
    logic [7:0] v;
    wr(1, 8'h55);
    chk("R5 mask load", mask_o, 8'h55);
    rd(1, v);
    chk("R6 mask read", v, 8'h55);
    ack(3'd3);
    chk("R14 ack sets isr", isr_o, 8'h08);
    wr(0, 8'hC2);
    chk("R11 setpri", {5'b0, rot_o}, 8'h03);
    wr(0, 8'h1B);
    chk("R4 req_clr pulse", req_clr_o, 8'hFF);
    chk("R4 int_clear", {7'b0, int_clear_o}, 8'h01);
    chk("R4 mask cleared", mask_o, 8'h00);
    chk("R4 isr cleared", isr_o, 8'h00);
    chk("R4 rot cleared", {5'b0, rot_o}, 8'h00);
    chk("R2 busy", {7'b0, init_busy_o}, 8'h01);
    @(negedge clk);
    chk("R4 pulse ends", {req_clr_o[7:1], int_clear_o}, 8'h00);
    wr(1, 8'h4D);
    chk("R2 base", base_o, 8'h48);
    wr(1, 8'h99);
    chk("R2 word3 discarded, word4 pending", {mask_o[6:0], init_busy_o}, 8'h01);
    wr(1, 8'h12);
    chk("R3 sfnm/aeoi", {6'b0, sfnm_o, aeoi_o}, 8'h03);
    chk("R3 back to run", {7'b0, init_busy_o}, 8'h00);
    chk("R13 level bit ignored, mask still zero", mask_o, 8'h00);
    // Start word without bit 0 but with bits 1 and 3 set: three words.
    wr(0, 8'h1A);
    wr(1, 8'h27);
    chk("R2 base second", base_o, 8'h20);
    wr(1, 8'h00);
    chk("R13 no fourth word", {7'b0, init_busy_o}, 8'h00);
    chk("R13 modes zero", {6'b0, sfnm_o, aeoi_o}, 8'h00);
    wr(1, 8'hA5);
    chk("R5 mask after init", mask_o, 8'hA5);
  endtask

  task automatic t_eoi;
    init_seq(8'h11, 8'h08, 8'h00);
    ack(3'd3);
    ack(3'd6);
    chk("R14 two in service", isr_o, 8'h48);
    wr(0, 8'h20);
    chk("R8 nonspecific clears line3", isr_o, 8'h40);
    ack(3'd1);
    wr(0, 8'hC4);
    chk("R11 rot = 4+1", {5'b0, rot_o}, 8'h05);
    wr(0, 8'hA0);
    chk("R9 rotated pick clears line6", isr_o, 8'h02);
    chk("R9 rot = 7", {5'b0, rot_o}, 8'h07);
    wr(0, 8'h61);
    chk("R10 specific clears line1", isr_o, 8'h00);
    wr(0, 8'h20);
    chk("R8 empty no effect", {isr_o[4:0], rot_o}, 8'h07);
    ack(3'd2);
    wr(0, 8'h40);
    chk("R11 code2 no-op", {isr_o[4:0], rot_o}, 8'h27);
    wr(0, 8'hE2);
    chk("R10 code7 clear", isr_o, 8'h00);
    chk("R10 code7 rot", {5'b0, rot_o}, 8'h03);
  endtask

  task automatic t_aeoi;
    init_seq(8'h11, 8'h08, 8'h02);
    wr(0, 8'h80);
    chk("R7 rotae set", {7'b0, rotae_o}, 8'h01);
    ack(3'd4);
    chk("R14 aeoi isr untouched", isr_o, 8'h00);
    chk("R14 aeoi rotate", {5'b0, rot_o}, 8'h05);
    wr(0, 8'h00);
    chk("R7 rotae cleared", {7'b0, rotae_o}, 8'h00);
    ack(3'd2);
    chk("R14 no rotate", {5'b0, rot_o}, 8'h05);
  endtask

  task automatic t_read;
    logic [7:0] v;
    init_seq(8'h10, 8'h00, 8'h00);
    req_in = 8'h3C;
    ack(3'd7);
    wr(0, 8'h0A);
    rd(0, v);
    chk("R6 read requests", v, 8'h3C);
    wr(0, 8'h0B);
    rd(0, v);
    chk("R6 read in-service", v, 8'h80);
    wr(0, 8'h08);
    rd(0, v);
    chk("R6 select kept", v, 8'h80);
    wr(0, 8'h68);
    chk("R6 smask set", {7'b0, smask_o}, 8'h01);
    wr(0, 8'h28);
    chk("R6 smask kept", {7'b0, smask_o}, 8'h01);
    wr(0, 8'h48);
    chk("R6 smask cleared", {7'b0, smask_o}, 8'h00);
  endtask

  task automatic t_poll;
    logic [7:0] v;
    init_seq(8'h10, 8'h00, 8'h00);
    wr(1, 8'h81);
    ack(3'd5);
    win_valid = 1'b1; win_line = 3'd5;
    wr(0, 8'h0C);
    rd(0, v);
    chk("R12 poll line", v, 8'h05);
    chk("R12 isr cleared", isr_o, 8'h00);
    chk("R12 req clear pulse", req_clr_o, 8'h20);
    rd(1, v);
    chk("R12 disarmed", v, 8'h81);
    win_valid = 1'b0;
    wr(0, 8'h0C);
    rd(1, v);
    chk("R12 nothing pending", v, 8'h07);
    chk("R12 no clear", req_clr_o, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; addr = 1'b0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    req_in = '0; win_valid = 1'b0; win_line = '0; ack_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_init;
    t_eoi;
    t_aeoi;
    t_read;
    t_poll;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule